// File: doc/BRIEF.md
# Turn-Synchronous Slice Filter Bank

This block is the arithmetic core of a bunch-by-bunch feedback processor. On every revolution of the machine it receives a fixed number of signed 8-bit samples taken across one particle bunch. Each sample position, or slice, is fed to its own finite impulse response filter. That filter runs over the slice's values from successive turns, not over neighbouring samples in the same turn. For each accepted slice the block returns one signed 8-bit correction sample, tagged with its slice number. All logic runs on a single clock that is derived from the machine's RF reference.

Turns are framed by two markers. A bunch marker begins a turn and resets the slice pointer. An injection marker wipes the filter history, because a newly injected beam has no past. Coefficients are signed fixed-point values written one at a time, by slice and tap. They are staged and go live only at the next bunch marker, so a turn never mixes two coefficient sets.

Samples enter over a valid/ready stream and results leave over a valid/ready stream. There is one output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result stays frozen and `in_ready` stays low. The markers and the coefficient port are plain single-cycle strobes that are never stalled.

Top module: `fir_slice_bank`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All coefficients and all history are zero, and sample beats accepted before the first bunch marker produce no output.
- R2: A beat accepted in the same cycle as a bunch marker is slice 0. Each later accepted beat of that turn is the next slice. `out_slice` carries the slice number and is always below NSLICE.
- R3: Beats accepted after the NSLICE-th beat of a turn are discarded and produce no output.
- R4: For slice s in a turn where the history is full, the result is y = sum over k = 0..NTAP-1 of c[s][k]·x[s](t−k). Here x[s](t−k) is the slice-s sample accepted k turns earlier, and tap 0 is the current sample.
- R5: Coefficients are signed 8-bit with 7 fractional bits. The sum is rounded by adding 64 and shifting right arithmetically by 7, then clipped to the range −128..127.
- R6: An injection marker clears the history and the turn count and parks the slice pointer. A beat offered in that cycle is dropped, and a bunch marker in that cycle is ignored. Coefficients are kept.
- R7: Counting bunch markers since injection or reset, turns 1 to NTAP−1 output exactly 0 for every slice. Full filtering starts from turn NTAP. Markers that arrive without samples still count.
- R8: A coefficient write sets the staged value at (`coef_slice`, `coef_tap`). The staged set becomes live at the next bunch marker, and that marker's own slice-0 beat already uses it. A write in the same cycle as a marker waits for the following marker.
- R9: A result held with `out_ready` low keeps `out_data` and `out_slice` stable, and `in_ready` is low meanwhile.
- R10: Each slice's history advances only when that slice is accepted, independently of the other slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-derived processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_mark | input | 1 | Injection strobe: clears history |
| bunch_mark | input | 1 | Turn-start strobe: slice pointer to 0, coefficient commit |
| in_valid | input | 1 | Sample beat offered |
| in_ready | output | 1 | Sample beat can be taken |
| in_data | input | 8 | Signed sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_slice | input | $clog2(NSLICE) | Slice addressed by the write |
| coef_tap | input | $clog2(NTAP) | Tap addressed by the write |
| coef_data | input | 8 | Signed Q1.7 coefficient |
| out_valid | output | 1 | Correction sample present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 8 | Signed correction sample |
| out_slice | output | $clog2(NSLICE) | Slice of the present result |

## Verification
A corrupted history or coefficient cell cannot stay hidden. It shows up in the very next result for that slice, and for a history cell in each later turn until the cell shifts out after NTAP turns. A slip in the slice pointer appears at once as a wrong `out_slice`, or as a missing or extra result in the same turn. An error in the fill count appears as a nonzero result inside the first NTAP−1 turns after injection, or as a zero result after them. A commit that arrives one marker late or early changes the turn's results from slice 0 onward.

// File: rtl/fir_bank_pkg.sv
package fir_bank_pkg;
  localparam int SAMPLE_W  = 8;
  localparam int COEF_W    = 8;
  localparam int COEF_FRAC = COEF_W - 1;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [COEF_W-1:0]   coef_t;
endpackage

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
  import fir_bank_pkg::*;
#(
  parameter int NSLICE = 16,
  parameter int NTAP   = 16,
  parameter int SW     = 4,
  parameter int TW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slice,
  input  logic [TW-1:0] wr_tap,
  input  coef_t         wr_data,
  input  logic          commit,
  input  logic [SW-1:0] rd_slice,
  input  logic          rd_staged,
  output coef_t         rd_row [NTAP]
);
  // staged and live copies; live reloads from staged on commit
  coef_t staged [NSLICE][NTAP];
  coef_t live   [NSLICE][NTAP];

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          staged[s][k] <= '0;
          live[s][k]   <= '0;
        end else begin
          if (commit)
            live[s][k] <= staged[s][k];
          if (wr_en && wr_slice == SW'(s) && wr_tap == TW'(k))
            staged[s][k] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NTAP; k++)
      rd_row[k] = rd_staged ? staged[rd_slice][k] : live[rd_slice][k];
  end
endmodule

// File: rtl/fir_hist_bank.sv
module fir_hist_bank
  import fir_bank_pkg::*;
#(
  parameter int NSLICE = 16,
  parameter int NTAP   = 16,
  parameter int SW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [SW-1:0] slice,
  input  sample_t       din,
  output sample_t       past [NTAP-1]
);
  localparam int DEPTH = NTAP - 1;

  // per-slice shift line of earlier turns, entry 0 is the newest
  sample_t line [NSLICE][DEPTH];

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) line[s][k] <= '0;
      end else if (clear) begin
        for (int k = 0; k < DEPTH; k++) line[s][k] <= '0;
      end else if (push && slice == SW'(s)) begin
        line[s][0] <= din;
        for (int k = 1; k < DEPTH; k++) line[s][k] <= line[s][k-1];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) past[k] = line[slice][k];
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac
  import fir_bank_pkg::*;
#(
  parameter int NTAP = 16
) (
  input  sample_t cur,
  input  sample_t past [NTAP-1],
  input  coef_t   coef [NTAP],
  input  logic    armed,
  output sample_t y
);
  localparam int PROD_W = SAMPLE_W + COEF_W;
  localparam int ACC_W  = PROD_W + $clog2(NTAP);
  localparam logic signed [ACC_W-1:0] HI   = ACC_W'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] LO   = -HI - 1;
  localparam logic signed [ACC_W-1:0] BIAS = ACC_W'(1) <<< (COEF_FRAC - 1);

  logic signed [PROD_W-1:0] prod [NTAP];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  scaled;

  for (genvar k = 0; k < NTAP; k++) begin : g_prod
    if (k == 0) begin : g_now
      assign prod[k] = cur * coef[k];
    end else begin : g_old
      assign prod[k] = past[k-1] * coef[k];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + ACC_W'(prod[k]);
    scaled = (acc + BIAS) >>> COEF_FRAC;
    if (!armed)          y = '0;
    else if (scaled > HI) y = HI[SAMPLE_W-1:0];
    else if (scaled < LO) y = LO[SAMPLE_W-1:0];
    else                 y = scaled[SAMPLE_W-1:0];
  end
endmodule

// File: rtl/fir_slice_bank.sv
module fir_slice_bank
  import fir_bank_pkg::*;
#(
  parameter int NSLICE = 16,
  parameter int NTAP   = 16,
  parameter int SW     = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  parameter int TW     = (NTAP > 1) ? $clog2(NTAP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_mark,
  input  logic          bunch_mark,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          coef_we,
  input  logic [SW-1:0] coef_slice,
  input  logic [TW-1:0] coef_tap,
  input  logic [7:0]    coef_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic [SW-1:0] out_slice
);
  localparam int PW = SW + 1;
  localparam int FW = $clog2(NTAP + 1);
  localparam logic [PW-1:0] PARK = PW'(NSLICE);
  localparam logic [FW-1:0] FULL = FW'(NTAP);

  logic [PW-1:0] ptr, ptr_eff;
  logic [FW-1:0] fill, fill_eff;
  logic          turn_start, take, in_range;
  logic [SW-1:0] sel;
  coef_t         row_c [NTAP];
  sample_t       row_h [NTAP-1];
  sample_t       result;

  assign turn_start = bunch_mark && !inj_mark;
  assign ptr_eff    = turn_start ? '0 : ptr;
  assign in_range   = ptr_eff < PARK;
  assign in_ready   = !out_valid || out_ready;
  assign take       = in_valid && in_ready && !inj_mark && in_range;
  assign sel        = in_range ? ptr_eff[SW-1:0] : '0;
  assign fill_eff   = (turn_start && fill != FULL) ? fill + 1'b1 : fill;

  fir_coef_bank #(.NSLICE(NSLICE), .NTAP(NTAP), .SW(SW), .TW(TW)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (coef_we),
    .wr_slice  (coef_slice),
    .wr_tap    (coef_tap),
    .wr_data   (coef_t'(coef_data)),
    .commit    (turn_start),
    .rd_slice  (sel),
    .rd_staged (turn_start),
    .rd_row    (row_c)
  );

  fir_hist_bank #(.NSLICE(NSLICE), .NTAP(NTAP), .SW(SW)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (inj_mark),
    .push  (take),
    .slice (sel),
    .din   (sample_t'(in_data)),
    .past  (row_h)
  );

  fir_mac #(.NTAP(NTAP)) u_mac (
    .cur   (sample_t'(in_data)),
    .past  (row_h),
    .coef  (row_c),
    .armed (fill_eff == FULL),
    .y     (result)
  );

  // turn sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= PARK;
      fill <= '0;
    end else if (inj_mark) begin
      ptr  <= PARK;
      fill <= '0;
    end else begin
      fill <= fill_eff;
      if (take)            ptr <= ptr_eff + 1'b1;
      else if (turn_start) ptr <= '0;
    end
  end

  // single result register on the output stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_slice <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= result;
      out_slice <= sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fir_slice_bank_chk.sv
module fir_slice_bank_chk #(
  parameter int NSLICE = 16,
  parameter int NTAP   = 16,
  parameter int SW     = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inj_mark,
  input logic          bunch_mark,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic [SW-1:0] out_slice
);
  int turns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            turns <= 0;
    else if (inj_mark)                     turns <= 0;
    else if (bunch_mark && turns < NTAP)   turns <= turns + 1;
  end

  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bunch_mark && !inj_mark && in_valid && in_ready && (turns + 1 < NTAP))
    |=> (out_valid && out_data == 8'd0 && out_slice == '0)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_slice))); // R9

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9

  AST_INJ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_mark && (!out_valid || out_ready)) |=> !out_valid); // R6

  AST_SLICE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_slice) < NSLICE)); // R2
endmodule

bind fir_slice_bank fir_slice_bank_chk #(.NSLICE(NSLICE), .NTAP(NTAP), .SW(SW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inj_mark   (inj_mark),
  .bunch_mark (bunch_mark),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_slice  (out_slice)
);

// File: tb/fir_slice_bank_test.sv
module fir_slice_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int NT = 4;
  localparam int SW = 2;
  localparam int TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inj_mark = 0, bunch_mark = 0, in_valid = 0, coef_we = 0, out_ready = 1;
  logic in_ready, out_valid;
  logic [7:0] in_data = '0, coef_data = '0, out_data;
  logic [SW-1:0] coef_slice = '0, out_slice;
  logic [TW-1:0] coef_tap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_slice_bank #(.NSLICE(NS), .NTAP(NT)) uut (
    .clk(clk), .rst_n(rst_n), .inj_mark(inj_mark), .bunch_mark(bunch_mark),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .coef_we(coef_we), .coef_slice(coef_slice), .coef_tap(coef_tap), .coef_data(coef_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_slice(out_slice)
  );

  int nchk = 0, nfail = 0;
  int hm [NS][NT];
  int ca [NS][NT];
  int cp [NS][NT];
  int idx_m = NS, fill_m = 0;
  int exp_d[$]; int exp_s[$]; string exp_t[$];
  string phase = "R4";
  logic hs_in = 0, bp_on = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // independent model of R4..R10
  task automatic model_step(input bit hi, input bit ij, input bit mk, input int din,
                            input bit we, input int ws, input int wt, input int wd);
    int eidx, acc, r; string tg;
    bit mke = mk && !ij;
    if (ij) begin
      foreach (hm[s, k]) hm[s][k] = 0;
      fill_m = 0; idx_m = NS;
    end else begin
      eidx = mke ? 0 : idx_m;
      if (mke) begin
        if (fill_m < NT) fill_m++;
        foreach (ca[s, k]) ca[s][k] = cp[s][k];
      end
      if (hi && eidx < NS) begin
        for (int k = NT-1; k > 0; k--) hm[eidx][k] = hm[eidx][k-1];
        hm[eidx][0] = din;
        acc = 0;
        for (int k = 0; k < NT; k++) acc += ca[eidx][k] * hm[eidx][k];
        r = (acc + 64) >>> 7;
        tg = phase;
        if (r > 127) begin r = 127; tg = "R5"; end
        if (r < -128) begin r = -128; tg = "R5"; end
        if (fill_m < NT) begin r = 0; tg = "R7"; end
        exp_d.push_back(r); exp_s.push_back(eidx); exp_t.push_back(tg);
        idx_m = eidx + 1;
      end else if (mke) idx_m = 0;
    end
    if (we) cp[ws][wt] = wd;
  endtask

  task automatic tick();
    bit ho, hi, ij, mk, we; int od, os, din, ws, wt, wd;
    string tg; int ed, es;
    ho = out_valid && out_ready; od = int'($signed(out_data)); os = int'(out_slice);
    hi = in_valid && in_ready; ij = inj_mark; mk = bunch_mark; din = int'($signed(in_data));
    we = coef_we; ws = int'(coef_slice); wt = int'(coef_tap); wd = int'($signed(coef_data));
    @(posedge clk);
    if (ho) begin
      if (exp_d.size() == 0) check(0, "R3/R6 unexpected output", od, 0);
      else begin
        ed = exp_d.pop_front(); es = exp_s.pop_front(); tg = exp_t.pop_front();
        check(od == ed, {tg, "/R10 out_data"}, od, ed);
        check(os == es, "R2 out_slice", os, es);
      end
    end
    model_step(hi, ij, mk, din, we, ws, wt, wd);
    hs_in = hi;
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
    #1;
  endtask

  task automatic beat(input bit mark, input int v);
    in_valid = 1; in_data = 8'(v);
    do begin
      bunch_mark = mark && in_ready;
      tick();
    end while (!hs_in);
    in_valid = 0; bunch_mark = 0;
  endtask

  task automatic mark_only(); bunch_mark = 1; tick(); bunch_mark = 0; endtask
  task automatic inject();    inj_mark = 1;   tick(); inj_mark = 0;   endtask

  task automatic wcoef(input int s, input int k, input int v, input bit with_mark);
    coef_we = 1; coef_slice = SW'(s); coef_tap = TW'(k); coef_data = 8'(v);
    bunch_mark = with_mark;
    tick();
    coef_we = 0; bunch_mark = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    foreach (hm[s, k]) begin hm[s][k] = 0; ca[s][k] = 0; cp[s][k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    // R1 reset state
    check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1 in_ready after reset", in_ready, 1);
    phase = "R1";
    for (int i = 0; i < 3; i++) beat(0, 9 + i);   // no marker yet: dropped
    // coefficient set A, committed by a marker (R8)
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < NT; k++) wcoef(s, k, (((s * 5 + k * 3) % 9) - 4) * 16, 0);
    mark_only();
    inject();
    // sweep: 64 turns cover every input byte value in each slice order
    for (int t = 0; t < 70; t++) begin
      phase = (t >= 50 && t < 54) ? "R8" : "R4";
      bp_on = (t >= 30);
      for (int s = 0; s < NS; s++) begin
        beat(s == 0, (((t * NS + s) * 37) % 256) - 128);
        if (t == 50 && s == 1) wcoef(0, 0, -100, 0);   // R8 staged mid-turn
      end
      if (t == 40) begin beat(0, 55); beat(0, -55); end   // R3 extras
      if (t == 51) wcoef(1, 1, 77, 1);                     // R8 write with marker
    end
    // saturation and rounding set (R5)
    phase = "R5";
    bp_on = 0;
    for (int k = 0; k < NT; k++) begin
      wcoef(0, k, (k == NT-1) ? 32 : 0, 0);
      wcoef(1, k, 127, 0);
      wcoef(2, k, -128, 0);
      wcoef(3, k, (k == 0) ? 64 : 0, 0);
    end
    for (int t = 0; t < 14; t++) begin
      beat(1, (t % 2) ? -7 : 100);
      beat(0, 127);
      beat(0, (t < 7) ? 127 : -128);
      beat(0, (t % 7) - 3);
    end
    // injection with marker and beat in the same cycle (R6), then refill (R7)
    phase = "R6";
    in_valid = 1; in_data = 8'd99; bunch_mark = 1; inj_mark = 1;
    tick();
    in_valid = 0; bunch_mark = 0; inj_mark = 0;
    mark_only();                                 // counts as a turn
    for (int t = 0; t < 6; t++) begin
      beat(1, 20 + t);
      for (int s = 1; s < NS; s++) beat(0, -40 + 11 * s + t);
    end
    repeat (12) tick();
    check(exp_d.size() == 0, "R3 missing outputs at end", exp_d.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule